// File: doc/BRIEF.md
# Framed Receive Stream Splitter with Trailer Capture

This block terminates a framed 32-bit receive stream. Each frame starts with a payload section and ends with a fixed trailer of application words. The source marks the first payload word with start-of-frame and start-of-payload, the last payload word with end-of-payload, and the last trailer word with end-of-frame. A remainder field travels with every word. The block passes payload words straight through to a valid/ready write port. Each of those words carries a count of its valid bytes. The block latches the trailer into a bank of application registers, which a descriptor engine later copies into the packet's final buffer descriptor, together with the packet's total payload byte length.

Back-pressure: a word moves on the input only in a cycle where `in_valid` and `in_ready` are both high. For a payload word, `in_ready` follows `pl_ready` combinationally and `pl_valid` mirrors `in_valid`, so the write port sets the pace. Trailer words and discarded words need no room downstream. Once a complete trailer is latched, `in_ready` stays low on every word until the descriptor engine pulses `ftr_ack`. The frame sequencing is checked as words arrive. Sequencing faults and trailer-length faults raise separate sticky flags, and only reset clears them.

Top module: `rx_footer_splitter`

## Requirements
- R1: An input word transfers only in a cycle with `in_valid` and `in_ready` both high. While a payload word is offered and `ftr_valid` is low, `pl_valid` is high and `in_ready` equals `pl_ready`.
- R2: A frame begins with a word carrying both `in_sof` and `in_sop`. Every payload word appears unchanged on `pl_data`, with `pl_last` high on the word that carries `in_eop`.
- R3: `pl_nbytes` is 4 for every payload word except the last one. On the last word it equals `in_rem` when `in_rem` is 1 to 4, and any other `in_rem` value counts as 4.
- R4: After end-of-payload, exactly 8 trailer words follow, the eighth carrying `in_eof`. In the cycle after that word is accepted, `ftr_valid` is high, trailer word k sits at `ftr_data[32k +: 32]`, and `pkt_bytes` holds the sum of the frame's `pl_nbytes`.
- R5: While `ftr_valid` is high, `in_ready` is low and `ftr_data` and `pkt_bytes` hold their values. A `ftr_ack` pulse clears `ftr_valid` one cycle later.
- R6: If a trailer ends with `in_eof` after a count other than 8 words, `err_len` rises and stays high until reset. `ftr_valid` stays low and `pkt_bytes` keeps its old value.
- R7: Between frames, a word without both `in_sof` and `in_sop` is accepted, is not forwarded, and sets `err_order`. `in_sof` or `in_sop` on a later word of a frame also sets `err_order`, as does `in_eop` inside the trailer. `in_eof` on a payload word sets `err_order` and ends the frame on that word (with `pl_last` high) and with no trailer. `err_order` is sticky until reset.
- R8: After reset `ftr_valid`, `err_order` and `err_len` are low, `pkt_bytes` is 0, and `in_ready` is high when `pl_ready` is high.
- R9: A `ftr_ack` pulse while `ftr_valid` is low has no effect. The next complete trailer is still published.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Receive stream word |
| in_rem | input | 4 | Valid-byte count, meaningful on the last payload word |
| in_sof | input | 1 | Start-of-frame marker |
| in_sop | input | 1 | Start-of-payload marker |
| in_eop | input | 1 | End-of-payload marker |
| in_eof | input | 1 | End-of-frame marker |
| in_valid | input | 1 | Source has a word |
| in_ready | output | 1 | Block accepts the word |
| pl_data | output | 32 | Forwarded payload word |
| pl_nbytes | output | 3 | Valid bytes in the forwarded word |
| pl_last | output | 1 | Forwarded word ends the payload |
| pl_valid | output | 1 | Payload word offered |
| pl_ready | input | 1 | Write port takes the payload word |
| ftr_data | output | 256 | Latched trailer, word k at bits 32k+31..32k |
| pkt_bytes | output | 16 | Payload byte length of the published packet |
| ftr_valid | output | 1 | Trailer bank holds an unconsumed packet |
| ftr_ack | input | 1 | Descriptor engine consumed the bank |
| err_order | output | 1 | Sticky marker-sequence error |
| err_len | output | 1 | Sticky trailer-length error |

## Verification
Two states are hard to reach from the ports. One is a source that keeps offering words while the bank is full: the bench holds `in_valid` high with a fresh frame start for several cycles before acknowledging, and checks that nothing is accepted and nothing changes. The other is a payload word that stalls because the write port is not ready. For this the bench lowers `pl_ready` in a fixed rotation during some frames, so that stalls land on the first word, on middle words and on the end-of-payload word. Short and long trailers and misplaced markers are driven as directed frames. Each is followed by a clean frame, which shows that the sequencer recovers.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BODY    = 2'd1,
    ST_TRAILER = 2'd2
  } rxf_state_e;
endpackage

// File: rtl/rxf_seq.sv
// Frame sequencer: tracks which section of the frame the next word belongs to,
// counts trailer words and raises the sticky error flags.
module rxf_seq
  import rxf_pkg::*;
#(
  parameter int FTR_WORDS = 8,
  parameter int IDX_W     = $clog2(FTR_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             sop,
  input  logic             eop,
  input  logic             eof,
  output logic             pay_sel,
  output logic             pay_first,
  output logic             pay_last,
  output logic             ftr_wr,
  output logic [IDX_W-1:0] ftr_idx,
  output logic             publish,
  output logic             err_order,
  output logic             err_len
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FTR_WORDS - 1);
  localparam logic [IDX_W-1:0] SAT_CNT  = IDX_W'(FTR_WORDS);

  rxf_state_e       state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             order_hit, len_hit;

  always_comb begin
    pay_first = (state_q == ST_IDLE) && sof && sop;
    pay_sel   = pay_first || (state_q == ST_BODY);
    pay_last  = pay_sel && (eop || eof);
    ftr_wr    = beat && (state_q == ST_TRAILER) && (cnt_q < SAT_CNT);
    ftr_idx   = cnt_q;
    publish   = beat && (state_q == ST_TRAILER) && eof && (cnt_q == LAST_IDX);
    len_hit   = beat && (state_q == ST_TRAILER) && eof && (cnt_q != LAST_IDX);
    order_hit = 1'b0;
    state_d   = state_q;
    cnt_d     = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (beat) begin
          order_hit = !pay_first || eof;
          if (pay_first && !eof) state_d = eop ? ST_TRAILER : ST_BODY;
          cnt_d = '0;
        end
      end
      ST_BODY: begin
        if (beat) begin
          order_hit = sof || sop || eof;
          if (eof)      state_d = ST_IDLE;
          else if (eop) state_d = ST_TRAILER;
          cnt_d = '0;
        end
      end
      ST_TRAILER: begin
        if (beat) begin
          order_hit = sof || sop || eop;
          if (eof) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else if (cnt_q != SAT_CNT) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      err_order <= 1'b0;
      err_len   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (order_hit) err_order <= 1'b1;
      if (len_hit)   err_len   <= 1'b1;
    end
  end
endmodule

// File: rtl/rxf_len_acc.sv
// Per-word byte count and running payload length of the current frame.
module rxf_len_acc #(
  parameter int BYTES = 4,
  parameter int REM_W = 4,
  parameter int LEN_W = 16,
  parameter int NB_W  = $clog2(BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             first,
  input  logic             last,
  input  logic [REM_W-1:0] rem,
  output logic [NB_W-1:0]  nbytes,
  output logic [LEN_W-1:0] run_q
);
  localparam logic [REM_W-1:0] REM_MAX = REM_W'(BYTES);
  localparam logic [NB_W-1:0]  NB_FULL = NB_W'(BYTES);

  logic [NB_W-1:0] rem_dec;

  always_comb begin
    if (rem != '0 && rem <= REM_MAX) rem_dec = rem[NB_W-1:0];
    else                             rem_dec = NB_FULL;
    nbytes = last ? rem_dec : NB_FULL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= '0;
    else if (step) run_q <= (first ? '0 : run_q) + LEN_W'(nbytes);
  end
endmodule

// File: rtl/rxf_ftr_bank.sv
// Trailer register bank with its full flag and the published packet length.
module rxf_ftr_bank #(
  parameter int FTR_WORDS = 8,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16,
  parameter int IDX_W     = $clog2(FTR_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           din,
  input  logic                        publish,
  input  logic                        ack,
  input  logic [LEN_W-1:0]            len_in,
  output logic                        full,
  output logic [FTR_WORDS*DATA_W-1:0] dout,
  output logic [LEN_W-1:0]            len_out
);
  for (genvar g = 0; g < FTR_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              word_q <= '0;
      else if (wr && idx == IDX_W'(g))         word_q <= din;
    end
    assign dout[g*DATA_W +: DATA_W] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      len_out <= '0;
    end else if (publish) begin
      full    <= 1'b1;
      len_out <= len_in;
    end else if (ack) begin
      full    <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_footer_splitter.sv
module rx_footer_splitter #(
  parameter int DATA_W    = 32,
  parameter int REM_W     = 4,
  parameter int FTR_WORDS = 8,
  parameter int LEN_W     = 16,
  localparam int BYTES    = DATA_W / 8,
  localparam int NB_W     = $clog2(BYTES + 1),
  localparam int IDX_W    = $clog2(FTR_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DATA_W-1:0]           in_data,
  input  logic [REM_W-1:0]            in_rem,
  input  logic                        in_sof,
  input  logic                        in_sop,
  input  logic                        in_eop,
  input  logic                        in_eof,
  input  logic                        in_valid,
  output logic                        in_ready,
  output logic [DATA_W-1:0]           pl_data,
  output logic [NB_W-1:0]             pl_nbytes,
  output logic                        pl_last,
  output logic                        pl_valid,
  input  logic                        pl_ready,
  output logic [FTR_WORDS*DATA_W-1:0] ftr_data,
  output logic [LEN_W-1:0]            pkt_bytes,
  output logic                        ftr_valid,
  input  logic                        ftr_ack,
  output logic                        err_order,
  output logic                        err_len
);
  logic             beat, pay_sel, pay_first, pay_last, ftr_wr, publish;
  logic [IDX_W-1:0] ftr_idx;
  logic [LEN_W-1:0] run_len;

  assign in_ready = !ftr_valid && (!pay_sel || pl_ready);
  assign beat     = in_valid && in_ready;
  assign pl_valid = in_valid && !ftr_valid && pay_sel;
  assign pl_data  = in_data;
  assign pl_last  = pay_last;

  rxf_seq #(.FTR_WORDS(FTR_WORDS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .beat(beat),
    .sof(in_sof), .sop(in_sop), .eop(in_eop), .eof(in_eof),
    .pay_sel(pay_sel), .pay_first(pay_first), .pay_last(pay_last),
    .ftr_wr(ftr_wr), .ftr_idx(ftr_idx), .publish(publish),
    .err_order(err_order), .err_len(err_len)
  );

  rxf_len_acc #(.BYTES(BYTES), .REM_W(REM_W), .LEN_W(LEN_W), .NB_W(NB_W)) u_len (
    .clk(clk), .rst_n(rst_n), .step(beat && pay_sel), .first(pay_first),
    .last(pay_last), .rem(in_rem), .nbytes(pl_nbytes), .run_q(run_len)
  );

  rxf_ftr_bank #(.FTR_WORDS(FTR_WORDS), .DATA_W(DATA_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(ftr_wr), .idx(ftr_idx), .din(in_data),
    .publish(publish), .ack(ftr_ack), .len_in(run_len),
    .full(ftr_valid), .dout(ftr_data), .len_out(pkt_bytes)
  );
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int DATA_W    = 32,
  parameter int FTR_WORDS = 8,
  parameter int LEN_W     = 16,
  parameter int NB_W      = 3,
  parameter int BYTES     = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic                        in_eof,
  input logic                        pl_valid,
  input logic                        pl_ready,
  input logic [NB_W-1:0]             pl_nbytes,
  input logic [FTR_WORDS*DATA_W-1:0] ftr_data,
  input logic [LEN_W-1:0]            pkt_bytes,
  input logic                        ftr_valid,
  input logic                        ftr_ack,
  input logic                        err_order,
  input logic                        err_len
);
  assert_pay_needs_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> in_valid);
  assert_ready_follows_sink_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && !pl_ready) |-> !in_ready);
  assert_nbytes_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> (pl_nbytes != '0 && pl_nbytes <= NB_W'(BYTES)));
  assert_publish_after_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ftr_valid) |-> $past(in_valid && in_ready && in_eof));
  assert_stall_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ftr_valid |-> !in_ready);
  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ftr_valid && !ftr_ack) |=> (ftr_valid && $stable(ftr_data) && $stable(pkt_bytes)));
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ftr_valid && ftr_ack) |=> !ftr_valid);
  assert_sticky_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |=> err_len);
  assert_sticky_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_order |=> err_order);
endmodule

bind rx_footer_splitter rxf_chk #(
  .DATA_W(DATA_W), .FTR_WORDS(FTR_WORDS), .LEN_W(LEN_W), .NB_W(NB_W), .BYTES(BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_eof(in_eof),
  .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_nbytes(pl_nbytes),
  .ftr_data(ftr_data), .pkt_bytes(pkt_bytes), .ftr_valid(ftr_valid), .ftr_ack(ftr_ack),
  .err_order(err_order), .err_len(err_len)
);

// File: tb/tb_rx_footer_splitter.sv
`timescale 1ns/1ps
module tb_rx_footer_splitter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  in_data = '0;
  logic [3:0]   in_rem = '0;
  logic         in_sof = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_eof = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  pl_data;
  logic [2:0]   pl_nbytes;
  logic         pl_last, pl_valid;
  logic         pl_ready = 1'b1;
  logic [255:0] ftr_data;
  logic [15:0]  pkt_bytes;
  logic         ftr_valid;
  logic         ftr_ack = 1'b0;
  logic         err_order, err_len;

  int n_checks = 0;
  int n_errs   = 0;
  int phase    = 0;

  always #2 clk = ~clk;

  rx_footer_splitter dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_rem(in_rem),
    .in_sof(in_sof), .in_sop(in_sop), .in_eop(in_eop), .in_eof(in_eof),
    .in_valid(in_valid), .in_ready(in_ready), .pl_data(pl_data),
    .pl_nbytes(pl_nbytes), .pl_last(pl_last), .pl_valid(pl_valid),
    .pl_ready(pl_ready), .ftr_data(ftr_data), .pkt_bytes(pkt_bytes),
    .ftr_valid(ftr_valid), .ftr_ack(ftr_ack), .err_order(err_order),
    .err_len(err_len)
  );

  // fields: npay[32:25] rem[24:21] nftr[20:17] bytes[16:1] ok[0]
  localparam logic [32:0] VEC [0:6] = '{
    {8'd8, 4'd4, 4'd8, 16'd32, 1'b1},
    {8'd8, 4'd1, 4'd8, 16'd29, 1'b1},
    {8'd1, 4'd3, 4'd8, 16'd3,  1'b1},
    {8'd3, 4'd0, 4'd8, 16'd12, 1'b1},
    {8'd5, 4'd7, 4'd8, 16'd20, 1'b1},
    {8'd4, 4'd2, 4'd7, 16'd0,  1'b0},
    {8'd2, 4'd4, 4'd9, 16'd0,  1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] dec_rem(input logic [3:0] r);
    return (r >= 4'd1 && r <= 4'd4) ? r[2:0] : 3'd4;
  endfunction

  // Offer one word, wait until accepted; payload checks are made just before the accepting edge.
  task automatic send(input logic [31:0] d, input logic [3:0] r,
                      input logic f_sof, input logic f_sop, input logic f_eop, input logic f_eof,
                      input bit stall, input bit exp_pay, input logic exp_last,
                      input logic [2:0] exp_nb);
    @(negedge clk);
    in_data = d; in_rem = r;
    in_sof = f_sof; in_sop = f_sop; in_eop = f_eop; in_eof = f_eof;
    in_valid = 1'b1;
    forever begin
      pl_ready = stall ? (phase % 3 != 1) : 1'b1;
      phase++;
      #1;
      if (exp_pay && !pl_ready)
        check(!in_ready && pl_valid, "R1", "stall passes back", {in_ready, pl_valid}, 2'b01);
      if (in_ready) begin
        if (exp_pay) begin
          check(pl_valid, "R1", "pl_valid on payload", pl_valid, 1);
          check(pl_data == d, "R2", "pl_data", pl_data, d);
          check(pl_last == exp_last, "R2", "pl_last", pl_last, exp_last);
          check(pl_nbytes == exp_nb, "R3", "pl_nbytes", pl_nbytes, exp_nb);
        end else begin
          check(!pl_valid, "R7", "no forward of non-payload", pl_valid, 0);
        end
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1;
    in_valid = 1'b0;
    pl_ready = 1'b1;
  endtask

  task automatic frame(input int tag, input int npay, input logic [3:0] r,
                       input int nftr, input bit stall);
    for (int i = 0; i < npay; i++)
      send({8'hA0, 8'(tag), 8'h00, 8'(i)}, r, i == 0, i == 0, i == npay - 1, 1'b0,
           stall, 1'b1, i == npay - 1, (i == npay - 1) ? dec_rem(r) : 3'd4);
    for (int j = 0; j < nftr; j++)
      send({8'hF0, 8'(tag), 8'h00, 8'(j)}, 4'd0, 1'b0, 1'b0, 1'b0, j == nftr - 1,
           1'b0, 1'b0, 1'b0, 3'd4);
  endtask

  task automatic check_footer(input int tag, input logic [15:0] bytes);
    check(ftr_valid, "R4", "ftr_valid after eof", ftr_valid, 1);
    for (int k = 0; k < 8; k++)
      check(ftr_data[32*k +: 32] == {8'hF0, 8'(tag), 8'h00, 8'(k)}, "R4", "footer word",
            ftr_data[32*k +: 32], {8'hF0, 8'(tag), 8'h00, 8'(k)});
    check(pkt_bytes == bytes, "R4", "pkt_bytes", pkt_bytes, bytes);
  endtask

  task automatic ack();
    @(negedge clk); ftr_ack = 1'b1;
    @(posedge clk); #1 ftr_ack = 1'b0;
    check(!ftr_valid, "R5", "ack clears ftr_valid", ftr_valid, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0; ftr_ack = 1'b0; pl_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check(!ftr_valid && !err_order && !err_len, "R8", "flags after reset",
          {ftr_valid, err_order, err_len}, 0);
    check(pkt_bytes == 16'd0, "R8", "pkt_bytes after reset", pkt_bytes, 0);
    check(in_ready, "R8", "in_ready after reset", in_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    do_reset();

    // Table of frames.
    for (int v = 0; v < 7; v++) begin
      logic [15:0] hold_len;
      hold_len = pkt_bytes;
      frame(v, int'(VEC[v][32:25]), VEC[v][24:21], int'(VEC[v][20:17]), v % 2 == 1);
      if (VEC[v][0]) begin
        check_footer(v, VEC[v][16:1]);
        if (v == 0) begin
          logic [255:0] snap;
          snap = ftr_data;
          // R5: a waiting new frame start must not be taken while the bank is full.
          @(negedge clk);
          in_data = 32'hDEAD_BEEF; in_sof = 1'b1; in_sop = 1'b1; in_eop = 1'b0; in_eof = 1'b0;
          in_valid = 1'b1;
          repeat (3) begin
            #1;
            check(!in_ready && !pl_valid, "R5", "blocked while full", {in_ready, pl_valid}, 0);
            @(negedge clk);
          end
          in_valid = 1'b0;
          check(ftr_data == snap && ftr_valid, "R5", "bank held", ftr_data[31:0], snap[31:0]);
        end
        ack();
      end else begin
        check(!ftr_valid, "R6", "no publish on bad trailer", ftr_valid, 0);
        check(err_len, "R6", "err_len set", err_len, 1);
        check(pkt_bytes == hold_len, "R6", "pkt_bytes kept", pkt_bytes, hold_len);
      end
    end
    check(!err_order, "R7", "well-formed frames raise no order error", err_order, 0);

    // R9: stray acknowledge while empty.
    @(negedge clk); ftr_ack = 1'b1;
    @(posedge clk); #1 ftr_ack = 1'b0;
    check(!ftr_valid, "R9", "ack while empty", ftr_valid, 0);
    frame(20, 2, 4'd4, 8, 1'b0);
    check_footer(20, 16'd8);
    ack();

    // R7: stray word between frames.
    do_reset();
    send(32'h1234_5678, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4);
    #1 check(err_order, "R7", "stray word flags order", err_order, 1);
    frame(21, 1, 4'd2, 8, 1'b0);
    check_footer(21, 16'd2);
    ack();

    // R7: eof on a payload word ends the frame without a trailer.
    do_reset();
    send(32'h0000_0001, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd4);
    send(32'h0000_0002, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd3);
    #1;
    check(err_order && !ftr_valid, "R7", "eof in payload aborts",
          {err_order, ftr_valid}, 2'b10);
    frame(22, 3, 4'd4, 8, 1'b1);
    check_footer(22, 16'd12);
    ack();

    // R7: start marker inside the trailer is flagged, trailer still published.
    do_reset();
    send(32'hA016_0000, 4'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4);
    for (int j = 0; j < 8; j++)
      send({8'hF0, 8'd23, 8'h00, 8'(j)}, 4'd0, 1'b0, j == 3, 1'b0, j == 7,
           1'b0, 1'b0, 1'b0, 3'd4);
    check(err_order, "R7", "marker inside trailer", err_order, 1);
    check_footer(23, 16'd4);
    ack();

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule